// File: doc/BRIEF.md
# Eight-bit timer/counter with a shared prescaler

This block is the interval timer of a small microcontroller. An eight-bit count register advances on one of two sources. The first is the instruction-cycle strobe `ce`. The second is an edge on the external pin `ext_clk`, which is synchronised to `clk` first. When the count wraps from FFh to 00h, a sticky flag is set in the interrupt control register. The flag, combined with its enable bit, raises `irq`. The CPU core reaches the count, option and control registers through a small write/read port.

A single 8-bit prescaler serves either the timer or the watchdog, and the assignment bit of the option register decides which. The ratio differs with the owner. While the timer owns the prescaler, the watchdog tick `wdt_tick` passes `ce` through unchanged. While the watchdog owns it, the timer takes its source events directly. The prescaler count is never visible on the read port. Any write to the count register holds off counting for two instruction cycles. The watchdog timeout counter that consumes `wdt_tick` is a separate block.

Top module: `tmr8_shared_div`

## Requirements
- R1: When option bit 5 is 0 and option bit 3 is 1, the count advances by one on every cycle in which `ce` is high, wrapping modulo 256.
- R2: When option bit 5 is 1, the count advances once for each rising edge of `ext_clk` if option bit 4 is 0, or once for each falling edge if option bit 4 is 1. The pin passes through a two-flop synchroniser.
- R3: A write to the count register (select 0) loads the written value. No increment occurs on the next two `ce` cycles that follow.
- R4: When option bit 3 is 0, the prescaler belongs to the timer and divides source events by 2^(n+1), where n is option bits 2:0. A write to the count register clears the prescaler.
- R5: When option bit 3 is 1, `wdt_tick` pulses once every 2^n `ce` cycles, where n is option bits 2:0. A `wdt_clr` pulse clears the prescaler, and a count write does not clear it. When option bit 3 is 0, `wdt_tick` equals `ce`. `wdt_tick` is never high without `ce`.
- R6: A wrap of the count from FFh to 00h sets bit 2 of the control register (select 2). The bit stays set until software writes the control register.
- R7: `irq` is high exactly when control bit 2 (flag) and control bit 5 (enable) are both 1.
- R8: While `sleep` is high, the count does not change and no overflow occurs.
- R9: Reset sets the option register (select 1) to FFh and the control register to 00h. The count register keeps its value through reset.
- R10: `rd_data` shows the count for select 0, the option register for select 1, the control register for select 2, and 00h for select 3. The option and control registers read back as written, apart from the hardware-set flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Instruction-cycle strobe |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 count, 1 option, 2 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source: 0 count, 1 option, 2 control, 3 none |
| rd_data | output | 8 | Read data (combinational) |
| ext_clk | input | 1 | External count pin, asynchronous |
| wdt_clr | input | 1 | Clears the prescaler while it belongs to the watchdog |
| sleep | input | 1 | Halts the timer |
| wdt_tick | output | 1 | Prescaled watchdog tick |
| irq | output | 1 | Timer interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit register width, two synchroniser stages and a two-cycle write stall. With these values, even the 1:256 timer ratio completes a full prescaler period within about 260 cycles, so the tick is checked one cycle before and exactly on its boundary. Wrap-around from FFh, the two-cycle stall right after a write, and the pin synchroniser latency can all be observed cycle by cycle through the read port.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned PRE_W = 8;
  localparam int unsigned RATE_W = 3;

  // option register bit positions (decoded by the timer)
  localparam int unsigned OPT_SRC    = 5;
  localparam int unsigned OPT_EDGE   = 4;
  localparam int unsigned OPT_ASSIGN = 3;
  // control register bit positions
  localparam int unsigned CTL_EN     = 5;
  localparam int unsigned CTL_FLAG   = 2;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_OPT  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Mask of low prescaler bits that must all be one for a tick.
  // Timer owner divides by 2^(rate+1), watchdog owner by 2^rate.
  function automatic logic [PRE_W-1:0] tap_mask(input logic [RATE_W-1:0] rate,
                                                input logic for_timer);
    logic [PRE_W:0] full;
    full = ({{PRE_W{1'b0}}, 1'b1} << (int'(rate) + int'(for_timer))) - 1'b1;
    return full[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/tmr8_edge_sync.sv
`timescale 1ns/1ps
module tmr8_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic pulse
);
  logic [STAGES:0] sh_q;
  logic cur, prev;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign cur   = sh_q[STAGES-1];
  assign prev  = sh_q[STAGES];
  assign pulse = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tmr8_prescaler.sv
`timescale 1ns/1ps
module tmr8_prescaler
  import tmr8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [RATE_W-1:0] rate,
  input  logic              for_timer,
  output logic              tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = tap_mask(rate, for_timer);
  assign tick = adv && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) pre_q <= '0;
    else if (adv)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr8_count_reg.sv
`timescale 1ns/1ps
module tmr8_count_reg #(
  parameter int unsigned W     = 8,
  parameter int unsigned STALL = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] q,
  output logic         blocked,
  output logic         ovf
);
  localparam int unsigned SW = $clog2(STALL + 1);

  logic [SW-1:0] stall_q;

  assign blocked = (stall_q != '0);
  assign ovf     = step && (q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)                 stall_q <= '0;
    else if (load)           stall_q <= SW'(STALL);
    else if (ce && blocked)  stall_q <= stall_q - 1'b1;
  end

  // no reset: the count survives every reset
  always_ff @(posedge clk) begin
    if (load)      q <= load_val;
    else if (step) q <= q + 1'b1;
  end
endmodule

// File: rtl/tmr8_shared_div.sv
`timescale 1ns/1ps
module tmr8_shared_div
  import tmr8_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STALL_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             ext_clk,
  input  logic             wdt_clr,
  input  logic             sleep,
  output logic             wdt_tick,
  output logic             irq
);
  logic [REG_W-1:0] opt_q, ctl_q, ctl_d, cnt_q;
  logic wr_cnt, wr_opt, wr_ctl;
  logic ext_pulse, blocked, src_raw, src_evt;
  logic for_timer, pre_adv, pre_clr, pre_tick;
  logic inc_evt, ovf_evt, ovf_flag;

  assign wr_cnt = wr_en && (reg_sel_e'(wr_sel) == SEL_CNT);
  assign wr_opt = wr_en && (reg_sel_e'(wr_sel) == SEL_OPT);
  assign wr_ctl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_clk),
    .fall_sel(opt_q[OPT_EDGE]), .pulse(ext_pulse)
  );

  // source event, gated by sleep, the write stall and a write in progress
  assign src_raw = opt_q[OPT_SRC] ? ext_pulse : ce;
  assign src_evt = src_raw && !sleep && !blocked && !wr_cnt;

  assign for_timer = !opt_q[OPT_ASSIGN];
  assign pre_adv   = for_timer ? src_evt : ce;
  assign pre_clr   = for_timer ? wr_cnt : wdt_clr;

  tmr8_prescaler u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .adv(pre_adv),
    .rate(opt_q[RATE_W-1:0]), .for_timer(for_timer), .tick(pre_tick)
  );

  assign inc_evt  = for_timer ? pre_tick : src_evt;
  assign wdt_tick = for_timer ? ce : pre_tick;

  tmr8_count_reg #(.W(REG_W), .STALL(STALL_CYC)) u_cnt (
    .clk(clk), .rst(rst), .ce(ce), .load(wr_cnt), .load_val(wr_data),
    .step(inc_evt), .q(cnt_q), .blocked(blocked), .ovf(ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (rst)         opt_q <= {REG_W{1'b1}};
    else if (wr_opt) opt_q <= wr_data;
  end

  always_comb begin
    ctl_d = wr_ctl ? wr_data : ctl_q;
    if (ovf_evt) ctl_d[CTL_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  assign ovf_flag = ctl_q[CTL_FLAG];
  assign irq      = ovf_flag && ctl_q[CTL_EN];

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CNT: rd_data = cnt_q;
      SEL_OPT: rd_data = opt_q;
      SEL_CTL: rd_data = ctl_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr8_checks.sv
`timescale 1ns/1ps
module tmr8_checks (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic       sleep,
  input logic       wr_cnt,
  input logic       wr_ctl,
  input logic       inc_evt,
  input logic       ovf_evt,
  input logic       ovf_flag,
  input logic [7:0] opt_q,
  input logic [7:0] cnt_q,
  input logic       wdt_tick
);
  assert_opt_reset_R9: assert property (@(posedge clk)
    rst |=> (opt_q == 8'hFF));

  assert_sleep_halt_R8: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !inc_evt);

  assert_write_stall_R3: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |-> ##1 !inc_evt ##1 !inc_evt);

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (inc_evt && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 8'd1));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_flag);

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !wr_ctl) |=> ovf_flag);

  assert_wdt_ce_R5: assert property (@(posedge clk) disable iff (rst)
    wdt_tick |-> ce);
endmodule

bind tmr8_shared_div tmr8_checks u_chk (
  .clk(clk), .rst(rst), .ce(ce), .sleep(sleep),
  .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .inc_evt(inc_evt), .ovf_evt(ovf_evt),
  .ovf_flag(ovf_flag), .opt_q(opt_q), .cnt_q(cnt_q), .wdt_tick(wdt_tick)
);

// File: tb/sim_tmr8_shared_div.sv
`timescale 1ns/1ps
module sim_tmr8_shared_div;
  logic clk = 1'b0;
  logic rst = 1'b1, ce = 1'b1, wr_en = 1'b0, ext_clk = 1'b0;
  logic wdt_clr = 1'b0, sleep = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic wdt_tick, irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tmr8_shared_div u0 (
    .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ext_clk(ext_clk), .wdt_clr(wdt_clr), .sleep(sleep),
    .wdt_tick(wdt_tick), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  opt;
    logic [7:0]  load;
    logic [15:0] cyc;
    logic [7:0]  exp;
  } vec_t;

  // option, loaded count, edges after the write, expected count
  localparam vec_t VECS [8] = '{
    '{8'h08, 8'h10, 16'd10,  8'h18},
    '{8'h00, 8'h20, 16'd10,  8'h24},
    '{8'h02, 8'h00, 16'd34,  8'h04},
    '{8'h07, 8'h05, 16'd257, 8'h05},
    '{8'h07, 8'h05, 16'd258, 8'h06},
    '{8'h08, 8'hFE, 16'd5,   8'h01},
    '{8'h01, 8'h40, 16'd2,   8'h40},
    '{8'h08, 8'h33, 16'd3,   8'h34}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      c += int'(wdt_tick);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int c;
    int first;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9, R10, R7: reset state
    rd(2'd1, v); chk("R9 option after reset", v, 8'hFF);
    rd(2'd2, v); chk("R9 control after reset", v, 8'h00);
    chk("R7 irq after reset", {7'd0, irq}, 8'h00);
    rd(2'd3, v); chk("R10 empty select", v, 8'h00);

    // R9: count survives reset (external mode, pin idle)
    wr(2'd0, 8'h5A);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(2'd0, v); chk("R9 count kept through reset", v, 8'h5A);
    rd(2'd1, v); chk("R9 option re-reset", v, 8'hFF);

    // R1, R3, R4: table of timer cases
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, VECS[i].opt);
      wr(2'd0, VECS[i].load);
      repeat (int'(VECS[i].cyc)) @(negedge clk);
      rd(2'd0, v);
      chk(VECS[i].opt[3] ? "R1 R3 direct table" : "R4 R3 prescaled table", v, VECS[i].exp);
    end
    rd(2'd1, v); chk("R10 option readback", v, 8'h08);

    // R2: rising edges on the pin
    wr(2'd1, 8'h28);
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    ext_pulses(4);
    rd(2'd0, v); chk("R2 rising edge count", v, 8'h04);
    // R2: falling edges
    wr(2'd1, 8'h38);
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    ext_pulses(3);
    rd(2'd0, v); chk("R2 falling edge count", v, 8'h03);

    // R8: sleep holds the count at FFh, no flag
    sleep = 1'b1;
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R8 count frozen in sleep", v, 8'hFF);
    rd(2'd2, v); chk("R8 no overflow in sleep", v, 8'h00);
    sleep = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk("R8 resumes after sleep", v, 8'h00);
    rd(2'd2, v); chk("R6 wrap sets flag", v, 8'h04);

    // R6, R7: overflow flag and interrupt
    wr(2'd2, 8'h20);
    wr(2'd0, 8'hFE);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R6 count at FFh", v, 8'hFF);
    rd(2'd2, v); chk("R6 flag clear before wrap", v, 8'h20);
    chk("R7 irq low before wrap", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rd(2'd0, v); chk("R6 count wrapped", v, 8'h00);
    rd(2'd2, v); chk("R6 flag set on wrap", v, 8'h24);
    chk("R7 irq on wrap", {7'd0, irq}, 8'h01);
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R6 flag sticky", v, 8'h24);
    wr(2'd2, 8'h20);
    rd(2'd2, v); chk("R6 software clear", v, 8'h20);
    chk("R7 irq after clear", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h04);
    chk("R7 irq masked", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h24);
    chk("R7 irq enabled", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h00);

    // R5: watchdog tick ratios
    wr(2'd1, 8'h0B);
    wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
    count_ticks(64, c);
    chk("R5 wdt 1:8 ticks", 8'(c), 8'd8);
    wr(2'd1, 8'h08);
    count_ticks(20, c);
    chk("R5 wdt 1:1 ticks", 8'(c), 8'd20);
    wr(2'd1, 8'h07);
    count_ticks(16, c);
    chk("R5 wdt passes ce when timer owns", 8'(c), 8'd16);
    // R5: count write leaves the watchdog prescaler alone
    wr(2'd1, 8'h0B);
    wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
    wr(2'd0, 8'h00);
    first = -1;
    for (int i = 0; i < 8; i++) begin
      if (wdt_tick && first < 0) first = i;
      @(negedge clk);
    end
    chk("R5 count write keeps wdt prescaler", 8'(first), 8'd6);

    finish_run();
  end
endmodule